// File: doc/BRIEF.md
# Hamming ECC Syndrome Corrector

This block checks one page of NAND data against its Hamming code. For each 256-byte unit it takes the 24-bit code computed while the data streamed in and the 24-bit code stored in the spare area. It XORs the two into a syndrome and sorts the result into one of four classes. A clean unit needs nothing. A single flipped code bit means the stored code is damaged but the data is good. A single flipped data bit can be corrected, and the block names the byte and the bit. Anything else is uncorrectable.

When correction is enabled and a unit holds a single data-bit error, the block performs one read-modify-write on a byte-wide buffer port to flip the failing bit in place. A 512-byte page is treated as two units handled in turn: the lower unit first, then the upper unit at buffer offset 256 with its own code pair. Their failure flags are ORed into one `fail` output. A request starts with a one-cycle `start` pulse and completes with a one-cycle `done` pulse. Results stay valid until the next request.

Top module: `ecc_syndrome_fixer`

## Requirements
- R1: The syndrome of a unit is calc XOR stored. The unit is classed clean (status 2'b00) when the syndrome is zero, or when either the calculated or the stored 24-bit code is all zeros.
- R2: A syndrome with exactly one bit set gives status 2'b10 (code-only error). The data buffer is not accessed for that unit.
- R3: A syndrome with exactly eleven bits set whose low 11 bits XOR bits [21:11] equal 11'h7FF gives status 2'b01 (corrected). The byte index output is syndrome[10:3] and the bit mask output is 1 << syndrome[2:0].
- R4: Every other syndrome gives status 2'b11 (uncorrectable). For any status other than 2'b01, the byte index and mask outputs of that unit are zero.
- R5: With fix_en high, a corrected unit causes one read of buffer address {unit, byte index}, with data returned the following cycle. The read is followed in the next cycle by one write of that data XOR the mask to the same address.
- R6: With fix_en low, or for a unit that is not correctable, the buffer is never written.
- R7: With page512 high, the lower unit (codes *_lo, buffer offset 0) is processed first and then the upper unit (codes *_hi, buffer offset 256). With page512 low, the *_hi codes are ignored and status_hi reads 2'b00.
- R8: fail is high after done exactly when some processed unit has status 2'b10 or 2'b11.
- R9: done is a one-cycle pulse that rises U + 2F rising edges after the edge that samples start. U is the number of units processed and F is the number of read-modify-writes. Inputs other than buf_rdata are needed only in the start cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | One-cycle request strobe, honoured only when idle |
| page512 | input | 1 | 1: two 256-byte units, 0: one unit |
| fix_en | input | 1 | Apply corrections to the buffer |
| calc_lo | input | 24 | Recomputed code, lower unit |
| stored_lo | input | 24 | Stored code, lower unit |
| calc_hi | input | 24 | Recomputed code, upper unit |
| stored_hi | input | 24 | Stored code, upper unit |
| buf_addr | output | 9 | Buffer byte address |
| buf_rd_en | output | 1 | Buffer read request |
| buf_rdata | input | 8 | Buffer read data, valid the cycle after buf_rd_en |
| buf_wr_en | output | 1 | Buffer write strobe |
| buf_wdata | output | 8 | Buffer write data |
| done | output | 1 | Completion pulse |
| status_lo | output | 2 | Class of lower unit |
| status_hi | output | 2 | Class of upper unit |
| err_byte_lo | output | 8 | Failing byte index, lower unit |
| err_byte_hi | output | 8 | Failing byte index, upper unit |
| err_mask_lo | output | 8 | Failing bit mask, lower unit |
| err_mask_hi | output | 8 | Failing bit mask, upper unit |
| fail | output | 1 | Combined failure flag |

## Verification
The assertions assume the buffer answers a read with data on the very next cycle. They also assume a new start arrives only after the previous done, so the mode and enable latched at start govern every access that follows. The bench models the buffer as a registered byte array with that one-cycle latency. It issues one request at a time and waits for done before driving the next set of codes. It builds every syndrome directly from a chosen byte, bit and stored code, so each class, including the complementary-halves corner, is reached on purpose.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;
  localparam int CODE_W = 24;   // bits of one unit's code word
  localparam int PAR_W  = 11;   // width of each parity half

  typedef enum logic [1:0] {
    ST_CLEAN    = 2'b00,
    ST_FIXED    = 2'b01,
    ST_CODE_ERR = 2'b10,
    ST_UNCORR   = 2'b11
  } ecc_status_e;
endpackage

// File: rtl/ecc_popcount.sv
module ecc_popcount #(
  parameter int W   = 24,
  parameter int GRP = 4,
  localparam int CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     bits,
  output logic [CNT_W-1:0] ones
);
  localparam int NG    = (W + GRP - 1) / GRP;
  localparam int PART_W = $clog2(GRP + 1);

  logic [NG*GRP-1:0] padded;
  logic [PART_W-1:0] part [NG];

  assign padded = (NG*GRP)'(bits);

  // first level: one small adder per group of bits
  for (genvar g = 0; g < NG; g++) begin : g_grp
    always_comb begin
      part[g] = '0;
      for (int i = 0; i < GRP; i++)
        part[g] = part[g] + PART_W'(padded[g*GRP + i]);
    end
  end

  // second level: sum the group counts
  always_comb begin
    ones = '0;
    for (int g = 0; g < NG; g++)
      ones = ones + CNT_W'(part[g]);
  end
endmodule

// File: rtl/ecc_unit_classify.sv
module ecc_unit_classify
  import ecc_fix_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int PW = PAR_W,
  localparam int IDX_W = PW - 3
) (
  input  logic [CW-1:0]    calc,
  input  logic [CW-1:0]    stored,
  output ecc_status_e      status,
  output logic [IDX_W-1:0] byte_idx,
  output logic [7:0]       bit_mask
);
  localparam int CNT_W = $clog2(CW + 1);

  logic [CW-1:0]    syn;
  logic [CNT_W-1:0] ones;
  logic [PW-1:0]    fold_calc, fold_stored, fold_diff;

  assign syn         = calc ^ stored;
  assign fold_calc   = calc[PW-1:0]   ^ calc[2*PW-1:PW];
  assign fold_stored = stored[PW-1:0] ^ stored[2*PW-1:PW];
  assign fold_diff   = fold_calc ^ fold_stored;

  ecc_popcount #(.W(CW), .GRP(4)) i_pop (
    .bits (syn),
    .ones (ones)
  );

  always_comb begin
    if (syn == '0 || calc == '0 || stored == '0)
      status = ST_CLEAN;
    else if (ones == CNT_W'(1))
      status = ST_CODE_ERR;
    else if (ones == CNT_W'(PW) && fold_diff == '1)
      status = ST_FIXED;
    else
      status = ST_UNCORR;
  end

  assign byte_idx = syn[PW-1:3];
  assign bit_mask = 8'b1 << syn[2:0];
endmodule

// File: rtl/ecc_syndrome_fixer.sv
module ecc_syndrome_fixer
  import ecc_fix_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int PW = PAR_W,
  localparam int IDX_W  = PW - 3,
  localparam int ADDR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              page512,
  input  logic              fix_en,
  input  logic [CW-1:0]     calc_lo,
  input  logic [CW-1:0]     stored_lo,
  input  logic [CW-1:0]     calc_hi,
  input  logic [CW-1:0]     stored_hi,
  output logic [ADDR_W-1:0] buf_addr,
  output logic              buf_rd_en,
  input  logic [7:0]        buf_rdata,
  output logic              buf_wr_en,
  output logic [7:0]        buf_wdata,
  output logic              done,
  output logic [1:0]        status_lo,
  output logic [1:0]        status_hi,
  output logic [IDX_W-1:0]  err_byte_lo,
  output logic [IDX_W-1:0]  err_byte_hi,
  output logic [7:0]        err_mask_lo,
  output logic [7:0]        err_mask_hi,
  output logic              fail
);
  localparam int NUNIT = 2;

  typedef enum logic [2:0] {
    S_IDLE, S_EVAL, S_READ, S_WRITE, S_DONE
  } fix_state_e;

  fix_state_e state_q, state_d;
  logic       unit_q, unit_d;
  logic       ld_en, rec_en, last_unit;
  logic       page512_q, fix_q, fail_q;

  logic [CW-1:0]    calc_q   [NUNIT];
  logic [CW-1:0]    stored_q [NUNIT];
  ecc_status_e      stat_q   [NUNIT];
  logic [IDX_W-1:0] byte_q   [NUNIT];
  logic [7:0]       mask_q   [NUNIT];

  ecc_status_e      cls_status;
  logic [IDX_W-1:0] cls_byte;
  logic [7:0]       cls_mask;
  logic             cls_fixed, cls_bad;

  // one classifier shared by both units
  ecc_unit_classify #(.CW(CW), .PW(PW)) i_cls (
    .calc     (calc_q[unit_q]),
    .stored   (stored_q[unit_q]),
    .status   (cls_status),
    .byte_idx (cls_byte),
    .bit_mask (cls_mask)
  );

  assign cls_fixed = (cls_status == ST_FIXED);
  assign cls_bad   = (cls_status == ST_CODE_ERR) || (cls_status == ST_UNCORR);
  assign last_unit = (unit_q == page512_q);

  // next-state logic
  always_comb begin
    state_d = state_q;
    unit_d  = unit_q;
    ld_en   = 1'b0;
    rec_en  = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (start) begin
          ld_en   = 1'b1;
          unit_d  = 1'b0;
          state_d = S_EVAL;
        end
      end
      S_EVAL: begin
        rec_en = 1'b1;
        if (cls_fixed && fix_q)
          state_d = S_READ;
        else if (last_unit)
          state_d = S_DONE;
        else
          unit_d = 1'b1;
      end
      S_READ:  state_d = S_WRITE;
      S_WRITE: begin
        if (last_unit) begin
          state_d = S_DONE;
        end else begin
          unit_d  = 1'b1;
          state_d = S_EVAL;
        end
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      unit_q    <= 1'b0;
      page512_q <= 1'b0;
      fix_q     <= 1'b0;
      fail_q    <= 1'b0;
      for (int u = 0; u < NUNIT; u++) begin
        calc_q[u]   <= '0;
        stored_q[u] <= '0;
        stat_q[u]   <= ST_CLEAN;
        byte_q[u]   <= '0;
        mask_q[u]   <= '0;
      end
    end else begin
      state_q <= state_d;
      unit_q  <= unit_d;
      if (ld_en) begin
        page512_q   <= page512;
        fix_q       <= fix_en;
        fail_q      <= 1'b0;
        calc_q[0]   <= calc_lo;
        stored_q[0] <= stored_lo;
        calc_q[1]   <= calc_hi;
        stored_q[1] <= stored_hi;
        for (int u = 0; u < NUNIT; u++) begin
          stat_q[u] <= ST_CLEAN;
          byte_q[u] <= '0;
          mask_q[u] <= '0;
        end
      end
      if (rec_en) begin
        stat_q[unit_q] <= cls_status;
        byte_q[unit_q] <= cls_fixed ? cls_byte : '0;
        mask_q[unit_q] <= cls_fixed ? cls_mask : '0;
        fail_q         <= fail_q | cls_bad;
      end
    end
  end

  // buffer port: read in S_READ, write back in S_WRITE
  assign buf_addr  = {unit_q, byte_q[unit_q]};
  assign buf_rd_en = (state_q == S_READ);
  assign buf_wr_en = (state_q == S_WRITE);
  assign buf_wdata = buf_rdata ^ mask_q[unit_q];

  assign done        = (state_q == S_DONE);
  assign status_lo   = stat_q[0];
  assign status_hi   = stat_q[1];
  assign err_byte_lo = byte_q[0];
  assign err_byte_hi = byte_q[1];
  assign err_mask_lo = mask_q[0];
  assign err_mask_hi = mask_q[1];
  assign fail        = fail_q;
endmodule

module ecc_fixer_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [8:0] buf_addr,
  input logic       buf_rd_en,
  input logic       buf_wr_en,
  input logic       done,
  input logic [1:0] status_lo,
  input logic [1:0] status_hi,
  input logic [7:0] err_mask_lo,
  input logic       fail,
  input logic       fix_q,
  input logic       page512_q
);
  assert_rd_wr_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(buf_rd_en && buf_wr_en));

  assert_write_follows_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_en |-> ($past(buf_rd_en) && buf_addr == $past(buf_addr)));

  assert_no_access_unfixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_rd_en || buf_wr_en) |-> fix_q);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_fail_or_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fail == (status_lo[1] | status_hi[1])));

  assert_mask_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status_lo == 2'b01) |-> ($countones(err_mask_lo) == 1));

  assert_hi_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !page512_q) |-> (status_hi == 2'b00));
endmodule

bind ecc_syndrome_fixer ecc_fixer_checker i_ecc_fixer_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .buf_addr    (buf_addr),
  .buf_rd_en   (buf_rd_en),
  .buf_wr_en   (buf_wr_en),
  .done        (done),
  .status_lo   (status_lo),
  .status_hi   (status_hi),
  .err_mask_lo (err_mask_lo),
  .fail        (fail),
  .fix_q       (fix_q),
  .page512_q   (page512_q)
);

// File: tb/test_ecc_syndrome_fixer.sv
`timescale 1ns/1ps
module test_ecc_syndrome_fixer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, page512 = 1'b0, fix_en = 1'b0;
  logic [23:0] calc_lo = '0, stored_lo = '0, calc_hi = '0, stored_hi = '0;
  logic [8:0]  buf_addr;
  logic        buf_rd_en, buf_wr_en, done, fail;
  logic [7:0]  buf_rdata, buf_wdata;
  logic [1:0]  status_lo, status_hi;
  logic [7:0]  err_byte_lo, err_byte_hi, err_mask_lo, err_mask_hi;

  int n_chk = 0, n_err = 0, wr_cnt = 0, cyc = 0;
  logic [7:0] mem [512];

  always #2.5 clk = ~clk;

  ecc_syndrome_fixer i_ecc_syndrome_fixer (
    .clk(clk), .rst_n(rst_n), .start(start), .page512(page512), .fix_en(fix_en),
    .calc_lo(calc_lo), .stored_lo(stored_lo), .calc_hi(calc_hi), .stored_hi(stored_hi),
    .buf_addr(buf_addr), .buf_rd_en(buf_rd_en), .buf_rdata(buf_rdata),
    .buf_wr_en(buf_wr_en), .buf_wdata(buf_wdata), .done(done),
    .status_lo(status_lo), .status_hi(status_hi),
    .err_byte_lo(err_byte_lo), .err_byte_hi(err_byte_hi),
    .err_mask_lo(err_mask_lo), .err_mask_hi(err_mask_hi), .fail(fail)
  );

  // buffer model with one-cycle read latency
  always @(posedge clk) begin
    if (buf_rd_en) buf_rdata <= mem[buf_addr];
    if (buf_wr_en) begin
      mem[buf_addr] <= buf_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'(a) ^ 8'h5A;
  endfunction

  task automatic fill_mem();
    for (int i = 0; i < 512; i++) mem[i] = pat(i);
  endtask

  // calc that yields a correctable syndrome at (byte, bit)
  function automatic logic [23:0] mk_fix(input logic [23:0] st, input logic [7:0] b, input logic [2:0] bit_i);
    logic [10:0] lo;
    lo = {b, bit_i};
    return st ^ {2'b00, ~lo, lo};
  endfunction

  // run one request; cyc = negedges until done is seen
  task automatic run(input bit p512, input bit fx, input logic [23:0] cl, sl, ch, sh);
    @(negedge clk);
    page512 = p512; fix_en = fx;
    calc_lo = cl; stored_lo = sl; calc_hi = ch; stored_hi = sh;
    start = 1'b1; wr_cnt = 0; cyc = 0;
    do begin
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end while (!done && cyc < 50);
  endtask

  task automatic chk_pulse(input string req);
    @(negedge clk);
    chk(done == 1'b0, req, done, 0);
  endtask

  task t_reset();
    chk(done == 0 && buf_rd_en == 0 && buf_wr_en == 0, "R9 reset", {done, buf_rd_en, buf_wr_en}, 0);
    chk(fail == 0 && status_lo == 0 && status_hi == 0, "R8 reset", {fail, status_lo, status_hi}, 0);
  endtask

  task t_clean();
    fill_mem();
    run(0, 1, 24'h3A5C71, 24'h3A5C71, 24'h0, 24'h0);
    chk(status_lo == 2'b00, "R1 equal codes", status_lo, 0);
    chk(fail == 0 && wr_cnt == 0, "R6 clean no write", {fail, 8'(wr_cnt)}, 0);
    chk(cyc == 2, "R9 clean latency", cyc, 2);
    chk_pulse("R9 pulse");
  endtask

  task t_zero_code();
    run(0, 1, 24'h123456, 24'h000000, 24'h0, 24'h0);
    chk(status_lo == 2'b00 && fail == 0, "R1 stored zero", status_lo, 0);
    run(0, 1, 24'h000000, 24'h2B1C0D, 24'h0, 24'h0);
    chk(status_lo == 2'b00 && fail == 0, "R1 calc zero", status_lo, 0);
  endtask

  task t_code_bit();
    fill_mem();
    run(0, 1, 24'h2B1C0D ^ 24'h020000, 24'h2B1C0D, 24'h0, 24'h0);
    chk(status_lo == 2'b10, "R2 code-only status", status_lo, 2);
    chk(fail == 1, "R8 code-only fail", fail, 1);
    chk(wr_cnt == 0 && err_mask_lo == 0, "R2 no access", wr_cnt, 0);
    chk(cyc == 2, "R2 no read latency", cyc, 2);
  endtask

  task t_correct();
    logic [23:0] st;
    st = 24'h1F0E3C;
    fill_mem();
    run(0, 1, mk_fix(st, 8'hA7, 3'd5), st, 24'h0, 24'h0);
    chk(status_lo == 2'b01 && fail == 0, "R3 corrected status", status_lo, 1);
    chk(err_byte_lo == 8'hA7, "R3 byte index", err_byte_lo, 8'hA7);
    chk(err_mask_lo == 8'h20, "R3 bit mask", err_mask_lo, 8'h20);
    chk(mem[9'h0A7] == (pat(9'h0A7) ^ 8'h20), "R5 byte fixed", mem[9'h0A7], pat(9'h0A7) ^ 8'h20);
    chk(wr_cnt == 1, "R5 one write", wr_cnt, 1);
    chk(cyc == 4, "R9 fix latency", cyc, 4);
    chk_pulse("R9 pulse after fix");
    fill_mem();
    run(0, 1, mk_fix(st, 8'h00, 3'd0), st, 24'h0, 24'h0);
    chk(err_byte_lo == 0 && err_mask_lo == 8'h01, "R3 byte 0 bit 0", {err_byte_lo, err_mask_lo}, 1);
    chk(mem[0] == (pat(0) ^ 8'h01), "R5 byte 0 fixed", mem[0], pat(0) ^ 8'h01);
    fill_mem();
    run(0, 1, mk_fix(st, 8'hFF, 3'd7), st, 24'h0, 24'h0);
    chk(err_byte_lo == 8'hFF && err_mask_lo == 8'h80, "R3 byte 255 bit 7", {err_byte_lo, err_mask_lo}, 16'hFF80);
    chk(mem[9'h0FF] == (pat(9'h0FF) ^ 8'h80), "R5 byte 255 fixed", mem[9'h0FF], pat(9'h0FF) ^ 8'h80);
  endtask

  task t_no_fix();
    logic [23:0] st;
    st = 24'h0C3A5F;
    fill_mem();
    run(0, 0, mk_fix(st, 8'h42, 3'd2), st, 24'h0, 24'h0);
    chk(status_lo == 2'b01 && err_byte_lo == 8'h42, "R6 status still reported", status_lo, 1);
    chk(wr_cnt == 0 && mem[9'h042] == pat(9'h042), "R6 buffer untouched", mem[9'h042], pat(9'h042));
    chk(cyc == 2, "R6 latency no fix", cyc, 2);
  endtask

  task t_uncorr();
    logic [23:0] st;
    st = 24'h35A1C7;
    fill_mem();
    run(0, 1, st ^ 24'h000BFF, st, 24'h0, 24'h0); // 11 ones, halves not complementary
    chk(status_lo == 2'b11 && fail == 1, "R4 eleven ones bad halves", status_lo, 3);
    chk(err_byte_lo == 0 && err_mask_lo == 0 && wr_cnt == 0, "R4 no index no write", err_mask_lo, 0);
    run(0, 1, st ^ 24'h000081, st, 24'h0, 24'h0); // two ones
    chk(status_lo == 2'b11 && fail == 1, "R4 two ones", status_lo, 3);
    run(0, 1, st ^ 24'hFFFFFF, st, 24'h0, 24'h0);
    chk(status_lo == 2'b11, "R4 all ones", status_lo, 3);
  endtask

  task t_page512();
    logic [23:0] st;
    st = 24'h2468AC;
    fill_mem();
    run(1, 1, st, st, mk_fix(st, 8'h10, 3'd3), st);
    chk(status_lo == 2'b00 && status_hi == 2'b01, "R7 upper corrected", status_hi, 1);
    chk(err_byte_hi == 8'h10 && err_mask_hi == 8'h08, "R7 upper index", err_mask_hi, 8'h08);
    chk(mem[9'h110] == (pat(9'h110) ^ 8'h08) && mem[9'h010] == pat(9'h010), "R7 upper offset 256", mem[9'h110], pat(9'h110) ^ 8'h08);
    chk(fail == 0 && cyc == 5, "R9 two-unit latency", cyc, 5);
    fill_mem();
    run(1, 1, mk_fix(st, 8'h33, 3'd1), st, st ^ 24'h000081, st);
    chk(status_lo == 2'b01 && status_hi == 2'b11, "R7 lower fixed upper bad", {status_lo, status_hi}, 4'b0111);
    chk(fail == 1, "R8 fail from upper", fail, 1);
    chk(mem[9'h033] == (pat(9'h033) ^ 8'h02), "R5 lower fixed in 512", mem[9'h033], pat(9'h033) ^ 8'h02);
    run(0, 1, st, st, st ^ 24'h000081, st);
    chk(status_hi == 2'b00 && fail == 0, "R7 upper ignored in 256", status_hi, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean();
        t_zero_code();
        t_code_bit();
        t_correct();
        t_no_fix();
        t_uncorr();
        t_page512();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule